// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block turns a configuration request into the architectural vector length of a vector unit. The register length and the widest supported element are fixed parameters. Each request carries a requested length, a new type word, and two flags that say whether the destination and source register indices of the request are zero. The block decodes the type word into an element width, a register grouping factor and two policy bits. Grouping may be fractional. The block rejects settings the unit cannot hold. It then updates its length register under a rule chosen by the two index flags.

The type register, the length register and the start-index register all live here. A request clears the start index. The surrounding unit can also load the start index directly between requests, for example when an operation is interrupted part way. Results appear one cycle after the request, marked by a one-cycle done pulse. The parameters must meet three rules: the register length and the widest element are powers of two, the register length is at least the widest element, and the register length is no more than 4096. The block checks these rules when it is elaborated.

Top module: `vcfg_unit`

## Requirements
- R1: The type word is decoded as follows. Bits [5:3] give the element width, 8 << field bits. Bits [2:0] give the grouping factor as a signed exponent, so a negative value n means 1/2^-n. Bit 6 is the tail policy and bit 7 is the mask policy. The outputs sew_bits_o, lmul_o, ta_o and ma_o report these fields.
- R2: The maximum length vlmax_o equals (VLEN / element width) × grouping factor, fractional factors included, with the fraction rounded down.
- R3: A type word is illegal in each of these cases: the grouping field is 3'b100, the element width exceeds the widest element scaled by min(grouping factor, 1), or any bit above bit 7 is set.
- R4: While the setting is illegal, these hold:
  - ill_o is 1.
  - vlmax_o and vl_o are 0.
  - vtype_o holds a word with only its most significant bit set.
  - sew_bits_o, lmul_o, ta_o and ma_o read 0.
- R5: When both index flags are set, the length keeps its old value, clamped to the new maximum.
- R6: When only the source flag is set, the length becomes the maximum.
- R7: When the source flag is clear, the length becomes min(requested length, maximum), whatever the destination flag is.
- R8: Each request clears the start index. Outside a request, a start-index load takes effect. When a request and a load arrive in the same cycle, the request wins.
- R9: After reset the unit is illegal: vl_o, vlmax_o and the start index are 0, and done_o is 0.
- R10: done_o is high for exactly the cycle after each request. Without a request, the length and type outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_req_i | input | 1 | Configuration request strobe |
| rd_zero_i | input | 1 | Destination register index is zero |
| rs1_zero_i | input | 1 | Source register index is zero |
| avl_i | input | XLEN | Requested length |
| vtype_i | input | XLEN | New type word |
| vstart_we_i | input | 1 | Load start index |
| vstart_i | input | $clog2(VLEN) | Start index to load |
| vl_o | output | $clog2(VLEN)+1 | Current vector length |
| vlmax_o | output | $clog2(VLEN)+1 | Current maximum length |
| vtype_o | output | XLEN | Stored type word |
| sew_bits_o | output | 11 | Element width in bits |
| lmul_o | output | 3 | Grouping exponent field |
| ta_o | output | 1 | Tail policy |
| ma_o | output | 1 | Mask policy |
| ill_o | output | 1 | Illegal setting |
| vstart_o | output | $clog2(VLEN) | Start index |
| done_o | output | 1 | Result valid, one cycle after request |

## Verification
The hardest case to reach is the clamp rule with both index flags set. It shows only when a type change shrinks the maximum below a length that a larger earlier configuration left behind. The stimulus table therefore chains its rows, so each row inherits the length of the one before. It also re-requests an unchanged type word, which exercises the path that skips decoding and uses the stored maximum. Fractional grouping is driven at the exact legality edge, where the element width equals the scaled widest element, and one step past that edge.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int unsigned SEW_W = 11;

  typedef struct packed {
    logic             ill;
    logic             ta;
    logic             ma;
    logic [2:0]       lmul;
    logic [SEW_W-1:0] sew;
  } vfields_t;
endpackage

// File: rtl/vtype_decode.sv
module vtype_decode import vcfg_pkg::*; #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64,
  localparam int unsigned VLW = $clog2(VLEN) + 1
) (
  input  logic [XLEN-1:0] vtype_i,
  output vfields_t        fields_o,
  output logic [VLW-1:0]  vlmax_o
);
  localparam int VLEN_LOG = $clog2(VLEN);
  localparam int ELEN_LOG = $clog2(ELEN);

  int  sew_log, lm, frac, e;
  logic bad;

  always_comb begin
    lm      = int'($signed(vtype_i[2:0]));
    sew_log = int'(vtype_i[5:3]) + 3;
    frac    = (lm < 0) ? -lm : 0;
    bad     = (vtype_i[2:0] == 3'b100) || (sew_log > ELEN_LOG - frac) || (|vtype_i[XLEN-1:8]);
    e       = VLEN_LOG - sew_log + lm;
    fields_o = '0;
    vlmax_o  = '0;
    if (bad) begin
      fields_o.ill = 1'b1;
    end else begin
      fields_o.sew  = SEW_W'(1) << sew_log;
      fields_o.lmul = vtype_i[2:0];
      fields_o.ta   = vtype_i[6];
      fields_o.ma   = vtype_i[7];
      if (e >= 0) vlmax_o = VLW'(1) << e;
    end
  end
endmodule

// File: rtl/vl_select.sv
module vl_select #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VLW  = 8
) (
  input  logic [VLW-1:0]  vlmax_i,
  input  logic [VLW-1:0]  old_vl_i,
  input  logic [XLEN-1:0] avl_i,
  input  logic            rd_zero_i,
  input  logic            rs1_zero_i,
  output logic [VLW-1:0]  vl_o
);
  always_comb begin
    if (vlmax_i == '0)
      vl_o = '0;
    else if (rd_zero_i && rs1_zero_i)
      vl_o = (old_vl_i > vlmax_i) ? vlmax_i : old_vl_i;
    else if (rs1_zero_i)
      vl_o = vlmax_i;
    else
      vl_o = (avl_i > XLEN'(vlmax_i)) ? vlmax_i : avl_i[VLW-1:0];
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit import vcfg_pkg::*; #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64,
  localparam int unsigned VLW = $clog2(VLEN) + 1,
  localparam int unsigned VSW = $clog2(VLEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_req_i,
  input  logic             rd_zero_i,
  input  logic             rs1_zero_i,
  input  logic [XLEN-1:0]  avl_i,
  input  logic [XLEN-1:0]  vtype_i,
  input  logic             vstart_we_i,
  input  logic [VSW-1:0]   vstart_i,
  output logic [VLW-1:0]   vl_o,
  output logic [VLW-1:0]   vlmax_o,
  output logic [XLEN-1:0]  vtype_o,
  output logic [SEW_W-1:0] sew_bits_o,
  output logic [2:0]       lmul_o,
  output logic             ta_o,
  output logic             ma_o,
  output logic             ill_o,
  output logic [VSW-1:0]   vstart_o,
  output logic             done_o
);
  localparam logic [XLEN-1:0] ILL_TYPE = {1'b1, {(XLEN-1){1'b0}}};
  localparam vfields_t        ILL_FIELDS = '{ill: 1'b1, default: '0};

  initial begin
    assert ((VLEN & (VLEN - 1)) == 0 && (ELEN & (ELEN - 1)) == 0)
      else $error("VLEN and ELEN must be powers of two");
    assert (VLEN >= ELEN && VLEN <= 4096 && ELEN >= 8)
      else $error("need 8 <= ELEN <= VLEN <= 4096");
  end

  logic [XLEN-1:0] vtype_q;
  vfields_t        f_q, dec_f;
  logic [VLW-1:0]  vlmax_q, dec_vlmax, eff_vlmax, vl_q, vl_d;
  logic [VSW-1:0]  vstart_q;
  logic            done_q, type_chg;

  vtype_decode #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) u_dec (
    .vtype_i (vtype_i),
    .fields_o(dec_f),
    .vlmax_o (dec_vlmax)
  );

  // decode only matters when the word changes; otherwise reuse stored max
  assign type_chg  = (vtype_i != vtype_q);
  assign eff_vlmax = type_chg ? dec_vlmax : vlmax_q;

  vl_select #(.XLEN(XLEN), .VLW(VLW)) u_sel (
    .vlmax_i   (eff_vlmax),
    .old_vl_i  (vl_q),
    .avl_i     (avl_i),
    .rd_zero_i (rd_zero_i),
    .rs1_zero_i(rs1_zero_i),
    .vl_o      (vl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vtype_q  <= ILL_TYPE;
      f_q      <= ILL_FIELDS;
      vlmax_q  <= '0;
      vl_q     <= '0;
      vstart_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= cfg_req_i;
      if (cfg_req_i) begin
        if (type_chg) begin
          vtype_q <= dec_f.ill ? ILL_TYPE : vtype_i;
          f_q     <= dec_f;
          vlmax_q <= dec_vlmax;
        end
        vl_q     <= vl_d;
        vstart_q <= '0;
      end else if (vstart_we_i) begin
        vstart_q <= vstart_i;
      end
    end
  end

  assign vl_o       = vl_q;
  assign vlmax_o    = vlmax_q;
  assign vtype_o    = vtype_q;
  assign sew_bits_o = f_q.sew;
  assign lmul_o     = f_q.lmul;
  assign ta_o       = f_q.ta;
  assign ma_o       = f_q.ma;
  assign ill_o      = f_q.ill;
  assign vstart_o   = vstart_q;
  assign done_o     = done_q;

  p_vl_le_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_o <= vlmax_o);
  p_ill_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_o |-> (vl_o == '0 && vlmax_o == '0 && vtype_o == ILL_TYPE));
  p_vstart_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_i |=> (vstart_o == '0));
  p_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_i |=> done_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_req_i |=> (!done_o && $stable(vl_o) && $stable(vtype_o)));
  p_src_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && rs1_zero_i && !rd_zero_i) |=> (vl_o == vlmax_o));
  p_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && rs1_zero_i && rd_zero_i) |=> (vl_o <= $past(vl_o)));
endmodule

// File: tb/vcfg_unit_tb_top.sv
module vcfg_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int VLW  = 8;
  localparam int VSW  = 7;
  localparam int NV   = 17;

  typedef struct packed {
    bit        rd0;
    bit        rs0;
    bit [31:0] avl;
    bit [31:0] vt;
    bit [7:0]  vl;
    bit [7:0]  vmax;
    bit        ill;
    bit [10:0] sew;
  } vec_t;

  // rows chain: each inherits the length left by the previous one
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'd100, 32'h00,  8'd16,  8'd16,  1'b0, 11'd8 },  // R7 clamp to max
    '{1'b0, 1'b0, 32'd5,   32'h00,  8'd5,   8'd16,  1'b0, 11'd8 },  // R7 below max
    '{1'b0, 1'b1, 32'd0,   32'h11,  8'd8,   8'd8,   1'b0, 11'd32},  // R6 lmul 2
    '{1'b1, 1'b1, 32'd0,   32'h0F,  8'd4,   8'd4,   1'b0, 11'd16},  // R5 shrink, lmul 1/2
    '{1'b1, 1'b1, 32'd0,   32'h03,  8'd4,   8'd128, 1'b0, 11'd8 },  // R5 no growth
    '{1'b0, 1'b0, 32'd200, 32'h03,  8'd128, 8'd128, 1'b0, 11'd8 },  // R2 largest max
    '{1'b0, 1'b0, 32'd9,   32'h1D,  8'd0,   8'd0,   1'b1, 11'd0 },  // R3 sew too wide for 1/8
    '{1'b0, 1'b0, 32'd1,   32'h05,  8'd1,   8'd2,   1'b0, 11'd8 },  // R2 lmul 1/8 edge
    '{1'b0, 1'b1, 32'd0,   32'h04,  8'd0,   8'd0,   1'b1, 11'd0 },  // R3 reserved lmul
    '{1'b0, 1'b0, 32'd3,   32'h100, 8'd0,   8'd0,   1'b1, 11'd0 },  // R3 high bit
    '{1'b0, 1'b0, 32'd3,   32'h0D,  8'd0,   8'd0,   1'b1, 11'd0 },  // R3 16 > 64/8
    '{1'b1, 1'b1, 32'd0,   32'h1F,  8'd0,   8'd0,   1'b1, 11'd0 },  // R3 64 > 64/2
    '{1'b0, 1'b1, 32'd0,   32'hD8,  8'd2,   8'd2,   1'b0, 11'd64},  // R1 policies set
    '{1'b0, 1'b0, 32'd4,   32'h23,  8'd0,   8'd0,   1'b1, 11'd0 },  // R3 sew 128 > ELEN
    '{1'b0, 1'b0, 32'd0,   32'h17,  8'd0,   8'd2,   1'b0, 11'd32},  // R7 zero request
    '{1'b1, 1'b0, 32'd7,   32'h17,  8'd2,   8'd2,   1'b0, 11'd32},  // R7 rd zero, same type
    '{1'b1, 1'b1, 32'd0,   32'h17,  8'd2,   8'd2,   1'b0, 11'd32}   // R5 same type kept
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, rd0 = 1'b0, rs0 = 1'b0, vs_we = 1'b0;
  logic [XLEN-1:0] avl = '0, vt = '0;
  logic [VSW-1:0]  vs_in = '0;
  logic [VLW-1:0]  vl, vlmax;
  logic [XLEN-1:0] vtype;
  logic [10:0]     sew;
  logic [2:0]      lmul;
  logic            ta, ma, ill, done;
  logic [VSW-1:0]  vstart;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [VLW-1:0] vl_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_req_i(req), .rd_zero_i(rd0), .rs1_zero_i(rs0),
    .avl_i(avl), .vtype_i(vt), .vstart_we_i(vs_we), .vstart_i(vs_in),
    .vl_o(vl), .vlmax_o(vlmax), .vtype_o(vtype), .sew_bits_o(sew), .lmul_o(lmul),
    .ta_o(ta), .ma_o(ma), .ill_o(ill), .vstart_o(vstart), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  task automatic cfg(input logic r, input logic s, input logic [31:0] a, input logic [31:0] t);
    @(negedge clk);
    req = 1'b1; rd0 = r; rs0 = s; avl = a; vt = t;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 vl", 32'(vl), 0);
    chk("R9 vlmax", 32'(vlmax), 0);
    chk("R9 ill", 32'(ill), 1);
    chk("R9 vstart", 32'(vstart), 0);
    chk("R9 done", 32'(done), 0);
    chk("R4 reset vtype", vtype, 32'h8000_0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cfg(VECS[i].rd0, VECS[i].rs0, VECS[i].avl, VECS[i].vt);
      chk("R10 done", 32'(done), 1);
      chk("R5/R6/R7 vl", 32'(vl), 32'(VECS[i].vl));
      chk("R2 vlmax", 32'(vlmax), 32'(VECS[i].vmax));
      chk("R3 ill", 32'(ill), 32'(VECS[i].ill));
      chk("R1 sew", 32'(sew), 32'(VECS[i].sew));
      chk("R1 lmul", 32'(lmul), VECS[i].ill ? 0 : 32'(VECS[i].vt[2:0]));
      chk("R1 ta", 32'(ta), VECS[i].ill ? 0 : 32'(VECS[i].vt[6]));
      chk("R1 ma", 32'(ma), VECS[i].ill ? 0 : 32'(VECS[i].vt[7]));
      chk("R4 vtype", vtype, VECS[i].ill ? 32'h8000_0000 : VECS[i].vt);
    end

    // R10 idle: outputs hold, done low
    vl_prev = vl;
    repeat (4) @(negedge clk);
    chk("R10 idle done", 32'(done), 0);
    chk("R10 idle vl", 32'(vl), 32'(vl_prev));

    // R8 start index load, then cleared by request
    vs_we = 1'b1; vs_in = 7'd45;
    @(negedge clk); vs_we = 1'b0;
    chk("R8 load", 32'(vstart), 45);
    cfg(1'b0, 1'b0, 32'd1, 32'h17);
    chk("R8 clear", 32'(vstart), 0);
    chk("R7 vl after load", 32'(vl), 1);
    // R8 request and load same cycle: request wins
    @(negedge clk);
    req = 1'b1; rd0 = 1'b0; rs0 = 1'b0; avl = 32'd2; vt = 32'h17;
    vs_we = 1'b1; vs_in = 7'd9;
    @(negedge clk);
    req = 1'b0; vs_we = 1'b0;
    chk("R8 same cycle", 32'(vstart), 0);

    // R4 request with the marker word itself
    cfg(1'b0, 1'b0, 32'd5, 32'h8000_0000);
    chk("R4 marker ill", 32'(ill), 1);
    chk("R4 marker vl", 32'(vl), 0);
    chk("R4 marker sew", 32'(sew), 0);
    cfg(1'b0, 1'b1, 32'd0, 32'h8000_0000);
    chk("R4 repeat marker vl", 32'(vl), 0);
    chk("R4 repeat marker vtype", vtype, 32'h8000_0000);
    // back to legal from illegal, R6
    cfg(1'b0, 1'b1, 32'd0, 32'h02);
    chk("R6 recover vl", 32'(vl), 64);
    chk("R3 recover ill", 32'(ill), 0);

    finish_run();
  end
endmodule